// File: doc/BRIEF.md
# Predicated Commit and Branch Target Unit

This unit sits beside the issue stage of a two-sided processor core and decides, for each issued instruction, whether its result may be committed. An instruction carries a predicate selector naming one of five condition registers (or none) and an invert flag. The unit senses whether the named register is zero and, from that and the invert flag, allows or blocks the commit. Branches are treated as ordinary predicated instructions. A branch that commits redirects the program counter and one that is blocked falls through.

Two branch forms are supported. The relative form carries a 21-bit signed word offset. The offset is scaled to bytes and added to the current program counter. The absolute form takes a full 32-bit target value read from a register. The absolute form may only be issued to the side-2 branch unit, and the unit refuses it when it arrives on side 1. All three outputs are registered and appear one clock after the request is sampled.

Top module: `pred_branch_unit`

## Requirements
- R1: With selector code 0 (no predicate) a valid non-rejected instruction commits; the invert flag is ignored.
- R2: Selector codes 1..5 name registers A1, A2, B0, B1, B2. With invert low, the instruction commits only when the named register is nonzero (any bit set, including bit 31).
- R3: With invert high, the instruction commits only when the named register equals zero.
- R4: Selector codes 6 and 7 are reserved, and an instruction carrying one never commits.
- R5: A branch request is taken only when the instruction commits; a branch whose predicate fails is not taken.
- R6: A taken relative branch sets the next PC to PC plus the sign-extended 21-bit offset shifted left by 2, over the full range -2^20 to 2^20-1 words. The side bit has no effect on this form.
- R7: A taken absolute branch (side bit 1, meaning side 2) sets the next PC to the 32-bit register value.
- R8: An absolute branch with side bit 0 (side 1) is rejected: no commit, not taken, next PC = PC+4.
- R9: Whenever no branch is taken, the next PC is PC+4, wrapping modulo 2^32.
- R10: With issue valid low, commit and branch-taken are both low.
- R11: Reset (active low, asynchronous) drives commit, branch-taken and next PC to zero.
- R12: Outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | An instruction is issued this cycle |
| predSel | input | 3 | Predicate selector: 0 none, 1 A1, 2 A2, 3 B0, 4 B1, 5 B2, 6-7 reserved |
| predInv | input | 1 | Invert the predicate sense |
| predA1 | input | 32 | Current value of register A1 |
| predA2 | input | 32 | Current value of register A2 |
| predB0 | input | 32 | Current value of register B0 |
| predB1 | input | 32 | Current value of register B1 |
| predB2 | input | 32 | Current value of register B2 |
| pc | input | 32 | Program counter of the issued instruction |
| brReq | input | 1 | The instruction is a branch |
| brAbs | input | 1 | 1: absolute register target, 0: relative offset |
| brSide | input | 1 | Branch unit side: 0 side 1, 1 side 2 |
| brOffset | input | 21 | Signed relative offset in instruction words |
| brRegVal | input | 32 | Absolute target value read from a register |
| commitEn | output | 1 | The instruction may commit |
| brTaken | output | 1 | The branch is taken |
| nextPc | output | 32 | Next program counter |

## Verification
The bench drives each predicate register with a value whose only set bit is in a different position, including bit 31. A design that tested only the low bits would then block an instruction predicated on A1. It runs relative branches at the extreme offsets +2^20-1 and -2^20 words, where a design that failed to sign-extend or scale the offset lands on a wrong target. It issues an absolute branch on side 1 and checks that the unit rejects it, so a design that ignores the side bit would branch. It also checks that reserved selectors block commit, that the invert flag has no effect when no predicate is selected, that a branch whose predicate fails falls through to PC+4, and that PC+4 wraps to zero at the top of the address space.

// File: rtl/pred_branch_pkg.sv
package pred_branch_pkg;
  localparam int XLEN       = 32;
  localparam int OFF_W      = 21;
  localparam int NUM_PRED   = 5;
  localparam int SEL_W      = 3;
  localparam int WORD_SHIFT = 2;

  // Selector code 0 means unpredicated; codes 1..NUM_PRED pick a register.
  localparam logic [SEL_W-1:0] SEL_NONE = '0;

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;
    logic take;
    logic useAbs;
  } peStrobe_t;
endpackage

// File: rtl/pred_branch_ctrl.sv
module pred_branch_ctrl
  import pred_branch_pkg::*;
#(
  parameter int P_XLEN     = XLEN,
  parameter int P_NUM_PRED = NUM_PRED,
  parameter int P_SEL_W    = SEL_W
) (
  input  logic                                issueValid,
  input  logic [P_SEL_W-1:0]                  predSel,
  input  logic                                predInv,
  input  logic [P_NUM_PRED-1:0][P_XLEN-1:0]   predRegs,
  input  logic                                brReq,
  input  logic                                brAbs,
  input  logic                                brSide,
  output peStrobe_t                           strobe
);
  logic [P_NUM_PRED-1:0] regNonZero;
  logic predOk;
  logic rejectAbs;

  for (genvar i = 0; i < P_NUM_PRED; i++) begin : g_sense
    assign regNonZero[i] = |predRegs[i];
  end

  always_comb begin
    predOk = 1'b0;
    if (predSel == SEL_NONE[P_SEL_W-1:0]) begin
      predOk = 1'b1;
    end else begin
      for (int i = 0; i < P_NUM_PRED; i++) begin
        if (predSel == P_SEL_W'(i + 1)) predOk = regNonZero[i] ^ predInv;
      end
    end
  end

  // Absolute form is only legal on the side-2 unit.
  assign rejectAbs = brReq && brAbs && !brSide;

  always_comb begin
    strobe.commit = issueValid && predOk && !rejectAbs;
    strobe.take   = strobe.commit && brReq;
    strobe.useAbs = brAbs;
  end
endmodule

// File: rtl/pred_branch_dp.sv
module pred_branch_dp
  import pred_branch_pkg::*;
#(
  parameter int P_XLEN       = XLEN,
  parameter int P_OFF_W      = OFF_W,
  parameter int P_WORD_SHIFT = WORD_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  peStrobe_t            strobe,
  input  logic [P_XLEN-1:0]    pc,
  input  logic [P_OFF_W-1:0]   brOffset,
  input  logic [P_XLEN-1:0]    brRegVal,
  output logic                 commitEn,
  output logic                 brTaken,
  output logic [P_XLEN-1:0]    nextPc
);
  localparam int EXT_W = P_XLEN - P_OFF_W - P_WORD_SHIFT;
  localparam logic [P_XLEN-1:0] STEP = P_XLEN'(1) << P_WORD_SHIFT;

  logic [P_XLEN-1:0] seqPc;
  logic [P_XLEN-1:0] relOfs;
  logic [P_XLEN-1:0] relTarget;
  logic [P_XLEN-1:0] pcNext;

  assign seqPc     = pc + STEP;
  assign relOfs    = {{EXT_W{brOffset[P_OFF_W-1]}}, brOffset, {P_WORD_SHIFT{1'b0}}};
  assign relTarget = pc + relOfs;

  always_comb begin
    if (!strobe.take)      pcNext = seqPc;
    else if (strobe.useAbs) pcNext = brRegVal;
    else                   pcNext = relTarget;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitEn <= 1'b0;
      brTaken  <= 1'b0;
      nextPc   <= '0;
    end else begin
      commitEn <= strobe.commit;
      brTaken  <= strobe.take;
      nextPc   <= pcNext;
    end
  end
endmodule

// File: rtl/pred_branch_unit.sv
module pred_branch_unit
  import pred_branch_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_OFF_W = OFF_W,
  parameter int P_SEL_W = SEL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [P_SEL_W-1:0] predSel,
  input  logic               predInv,
  input  logic [P_XLEN-1:0]  predA1,
  input  logic [P_XLEN-1:0]  predA2,
  input  logic [P_XLEN-1:0]  predB0,
  input  logic [P_XLEN-1:0]  predB1,
  input  logic [P_XLEN-1:0]  predB2,
  input  logic [P_XLEN-1:0]  pc,
  input  logic               brReq,
  input  logic               brAbs,
  input  logic               brSide,
  input  logic [P_OFF_W-1:0] brOffset,
  input  logic [P_XLEN-1:0]  brRegVal,
  output logic               commitEn,
  output logic               brTaken,
  output logic [P_XLEN-1:0]  nextPc
);
  logic [NUM_PRED-1:0][P_XLEN-1:0] predRegs;
  peStrobe_t strobe;

  // Entry i serves selector code i+1.
  assign predRegs = {predB2, predB1, predB0, predA2, predA1};

  pred_branch_ctrl #(
    .P_XLEN(P_XLEN), .P_NUM_PRED(NUM_PRED), .P_SEL_W(P_SEL_W)
  ) u_ctrl (
    .issueValid(issueValid), .predSel(predSel), .predInv(predInv),
    .predRegs(predRegs), .brReq(brReq), .brAbs(brAbs), .brSide(brSide),
    .strobe(strobe)
  );

  pred_branch_dp #(
    .P_XLEN(P_XLEN), .P_OFF_W(P_OFF_W), .P_WORD_SHIFT(WORD_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pc(pc),
    .brOffset(brOffset), .brRegVal(brRegVal),
    .commitEn(commitEn), .brTaken(brTaken), .nextPc(nextPc)
  );
endmodule

// File: rtl/pred_branch_unit_chk.sv
module pred_branch_unit_chk #(
  parameter int P_XLEN  = 32,
  parameter int P_OFF_W = 21,
  parameter int P_SEL_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               issueValid,
  input logic [P_SEL_W-1:0] predSel,
  input logic               predInv,
  input logic [P_XLEN-1:0]  predA1,
  input logic [P_XLEN-1:0]  predB0,
  input logic [P_XLEN-1:0]  pc,
  input logic               brReq,
  input logic               brAbs,
  input logic               brSide,
  input logic [P_OFF_W-1:0] brOffset,
  input logic [P_XLEN-1:0]  brRegVal,
  input logic               commitEn,
  input logic               brTaken,
  input logic [P_XLEN-1:0]  nextPc
);
  localparam int EXT_W = P_XLEN - P_OFF_W - 2;

  logic rejectReq;
  assign rejectReq = brReq && brAbs && !brSide;

  AST_UNPRED_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && predSel == '0 && !rejectReq) |=> commitEn); // R1

  AST_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && predSel == P_SEL_W'(1) && !predInv && predA1 == '0) |=> !commitEn); // R2

  AST_INV_ZERO_COMMITS: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && predSel == P_SEL_W'(3) && predInv && predB0 == '0 && !rejectReq) |=> commitEn); // R3

  AST_RESERVED_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (predSel > P_SEL_W'(5)) |=> !commitEn); // R4

  AST_TAKEN_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    brTaken |-> commitEn); // R5

  AST_REL_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && brTaken && !$past(brAbs)) |->
      nextPc == $past(pc) + {{EXT_W{$past(brOffset[P_OFF_W-1])}}, $past(brOffset), 2'b00}); // R6

  AST_ABS_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && brTaken && $past(brAbs)) |-> nextPc == $past(brRegVal)); // R7

  AST_SIDE1_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    rejectReq |=> (!commitEn && !brTaken)); // R8

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !brTaken) |-> nextPc == $past(pc) + P_XLEN'(4)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |=> (!commitEn && !brTaken)); // R10
endmodule

bind pred_branch_unit pred_branch_unit_chk #(
  .P_XLEN(P_XLEN), .P_OFF_W(P_OFF_W), .P_SEL_W(P_SEL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .predSel(predSel),
  .predInv(predInv), .predA1(predA1), .predB0(predB0), .pc(pc),
  .brReq(brReq), .brAbs(brAbs), .brSide(brSide), .brOffset(brOffset),
  .brRegVal(brRegVal), .commitEn(commitEn), .brTaken(brTaken), .nextPc(nextPc)
);

// File: tb/pred_branch_unit_bench.sv
module pred_branch_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [2:0]  predSel = '0;
  logic        predInv = 1'b0;
  logic [31:0] predA1 = '0, predA2 = '0, predB0 = '0, predB1 = '0, predB2 = '0;
  logic [31:0] pc = '0;
  logic        brReq = 1'b0, brAbs = 1'b0, brSide = 1'b0;
  logic [20:0] brOffset = '0;
  logic [31:0] brRegVal = '0;
  logic        commitEn, brTaken;
  logic [31:0] nextPc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pred_branch_unit u_pred_branch_unit (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .predSel(predSel),
    .predInv(predInv), .predA1(predA1), .predA2(predA2), .predB0(predB0),
    .predB1(predB1), .predB2(predB2), .pc(pc), .brReq(brReq), .brAbs(brAbs),
    .brSide(brSide), .brOffset(brOffset), .brRegVal(brRegVal),
    .commitEn(commitEn), .brTaken(brTaken), .nextPc(nextPc)
  );

  // mask bits: [0] A1, [1] A2, [2] B0, [3] B1, [4] B2 nonzero
  typedef struct packed {
    logic        valid;
    logic [2:0]  sel;
    logic        inv;
    logic [4:0]  mask;
    logic        req;
    logic        abs;
    logic        side;
    logic [20:0] off;
    logic [31:0] tgt;
    logic [31:0] pc;
    logic        eCommit;
    logic        eTaken;
    logic [31:0] ePc;
    logic [3:0]  rid;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,3'd0,1'b1,5'b00000,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'h100,     1'b1,1'b0,32'h104,     4'd1},  // R1
    '{1'b1,3'd1,1'b0,5'b00001,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'h200,     1'b1,1'b0,32'h204,     4'd2},  // R2
    '{1'b1,3'd1,1'b0,5'b11110,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'h200,     1'b0,1'b0,32'h204,     4'd2},  // R2
    '{1'b1,3'd3,1'b1,5'b11011,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'h300,     1'b1,1'b0,32'h304,     4'd3},  // R3
    '{1'b1,3'd3,1'b1,5'b00100,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'h300,     1'b0,1'b0,32'h304,     4'd3},  // R3
    '{1'b1,3'd6,1'b0,5'b11111,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'h400,     1'b0,1'b0,32'h404,     4'd4},  // R4
    '{1'b1,3'd7,1'b1,5'b00000,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'h400,     1'b0,1'b0,32'h404,     4'd4},  // R4
    '{1'b1,3'd5,1'b0,5'b10000,1'b1,1'b0,1'b1,21'h10,    32'h0,       32'h1000,    1'b1,1'b1,32'h1040,    4'd6},  // R6 predicated on B2
    '{1'b1,3'd0,1'b0,5'b00000,1'b1,1'b0,1'b1,21'h1FFFFF,32'h0,       32'h1000,    1'b1,1'b1,32'hFFC,     4'd6},  // R6 -1 word
    '{1'b1,3'd0,1'b0,5'b00000,1'b1,1'b0,1'b1,21'h0FFFFF,32'h0,       32'h400000,  1'b1,1'b1,32'h7FFFFC,  4'd6},  // R6 max
    '{1'b1,3'd0,1'b0,5'b00000,1'b1,1'b0,1'b1,21'h100000,32'h0,       32'h400000,  1'b1,1'b1,32'h0,       4'd6},  // R6 min
    '{1'b1,3'd4,1'b0,5'b10111,1'b1,1'b0,1'b1,21'h10,    32'h0,       32'h2000,    1'b0,1'b0,32'h2004,    4'd5},  // R5 failed predicate
    '{1'b1,3'd0,1'b0,5'b00000,1'b1,1'b1,1'b1,21'h0,     32'hDEADBEE0,32'h3000,    1'b1,1'b1,32'hDEADBEE0,4'd7},  // R7
    '{1'b1,3'd0,1'b0,5'b00000,1'b1,1'b1,1'b0,21'h0,     32'hDEADBEE0,32'h3000,    1'b0,1'b0,32'h3004,    4'd8},  // R8
    '{1'b1,3'd2,1'b1,5'b11101,1'b1,1'b1,1'b1,21'h0,     32'h00ABC000,32'h5000,    1'b1,1'b1,32'h00ABC000,4'd7},  // R7 inverted A2
    '{1'b1,3'd0,1'b0,5'b00000,1'b1,1'b0,1'b0,21'h1,     32'h0,       32'h6000,    1'b1,1'b1,32'h6004,    4'd6},  // R6 side 1 relative
    '{1'b1,3'd0,1'b0,5'b00000,1'b0,1'b0,1'b0,21'h0,     32'h0,       32'hFFFFFFFC,1'b1,1'b0,32'h0,       4'd9},  // R9 wrap
    '{1'b0,3'd0,1'b0,5'b00000,1'b1,1'b0,1'b1,21'h10,    32'h0,       32'h7000,    1'b0,1'b0,32'h7004,    4'd10}  // R10
  };

  task automatic apply(input vec_t v);
    issueValid = v.valid;
    predSel    = v.sel;
    predInv    = v.inv;
    predA1     = v.mask[0] ? 32'h8000_0000 : 32'h0;
    predA2     = v.mask[1] ? 32'h0000_0001 : 32'h0;
    predB0     = v.mask[2] ? 32'h0000_0010 : 32'h0;
    predB1     = v.mask[3] ? 32'h0000_0100 : 32'h0;
    predB2     = v.mask[4] ? 32'h0001_0000 : 32'h0;
    brReq      = v.req;
    brAbs      = v.abs;
    brSide     = v.side;
    brOffset   = v.off;
    brRegVal   = v.tgt;
    pc         = v.pc;
  endtask

  task automatic check(input string tag, input logic aC, input logic aT, input logic [31:0] aP,
                       input logic eC, input logic eT, input logic [31:0] eP);
    checks++;
    if (aC !== eC || aT !== eT || aP !== eP) begin
      errors++;
      $display("FAIL %s: got commit=%0b taken=%0b pc=%h, expected commit=%0b taken=%0b pc=%h",
               tag, aC, aT, aP, eC, eT, eP);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    #12;
    check("R11 reset", commitEn, brTaken, nextPc, 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d", VECS[i].rid, i), commitEn, brTaken, nextPc,
            VECS[i].eCommit, VECS[i].eTaken, VECS[i].ePc);
    end

    // R12: output holds until the next rising edge
    @(negedge clk);
    apply('{1'b1,3'd0,1'b0,5'b0,1'b0,1'b0,1'b0,21'h0,32'h0,32'h8000,1'b1,1'b0,32'h8004,4'd12});
    #3;
    check("R12 before edge", commitEn, brTaken, nextPc, 1'b0, 1'b0, 32'h7004);
    @(posedge clk);
    #1;
    check("R12 after edge", commitEn, brTaken, nextPc, 1'b1, 1'b0, 32'h8004);

    // R11: asynchronous reset mid-run, with a taken branch pending
    @(negedge clk);
    apply('{1'b1,3'd0,1'b0,5'b0,1'b1,1'b1,1'b1,21'h0,32'h1234_5678,32'h9000,1'b1,1'b1,32'h1234_5678,4'd7});
    @(posedge clk);
    #1;
    check("R7 before reset", commitEn, brTaken, nextPc, 1'b1, 1'b1, 32'h1234_5678);
    #2;
    rstN = 1'b0;
    #1;
    check("R11 async reset", commitEn, brTaken, nextPc, 1'b0, 1'b0, 32'h0);
    @(posedge clk);
    #1;
    check("R11 held in reset", commitEn, brTaken, nextPc, 1'b0, 1'b0, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule